// File: doc/BRIEF.md
# Maskable Input-Change Interrupt Unit

This unit watches a small parallel input port and pulls an active-low interrupt line when one of the inputs moves away from the value it had when software last read the port. Every input bit has its own mask bit that decides whether its change may reach the interrupt line. A read-only source register tells software which enabled inputs are currently causing the interrupt.

Each input is resynchronised by two flops and then compared with a reference snapshot. A set difference bit is a pending change. The snapshot is refreshed whenever the surrounding logic pulses the port-read strobe. A masked change is kept rather than dropped, so clearing its mask bit later raises the interrupt at once. Setting the mask bit of an active source withdraws that source straight away. A small register port gives access to the mask register at offset 45h and to the source register at offset 46h.

Top module: `chg_irq`

## Requirements
- R1: After reset the mask register reads FFh, the source register reads 00h, the reference snapshot is 00h, `irq_n` is high and `rd_data` is 00h.
- R2: Every input passes through two synchronising flops. A change driven before rising edge k shows on `irq_n` and in the source register after edge k+1, and not after edge k.
- R3: A pending change on an input whose mask bit is 0 drives `irq_n` low.
- R4: A change on an input whose mask bit is 1 leaves `irq_n` high and reads 0 in the source register, but it stays pending.
- R5: Writing 0 to the mask bit of a pending input drives `irq_n` low from the edge that takes the write.
- R6: Writing 1 to the mask bit of an active source releases `irq_n` from the next edge, unless another pending input is still unmasked.
- R7: Bit i of the source register at 46h reads as (pending i) AND NOT (mask i). Read data appears on `rd_data` at the edge that samples `rd_en` and holds until the next read.
- R8: A pulse on `port_rd` loads the synchronised inputs into the reference snapshot and clears every pending bit. `irq_n` is high on the following cycle when the inputs are steady.
- R9: A pending bit clears by itself when its input returns to the reference value.
- R10: The mask register at 45h can be written and read back. Writes to 46h and to any other offset change nothing. Reads of any offset other than 45h and 46h return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins | input | 8 | Asynchronous input port |
| port_rd | input | 1 | Strobe: input port was read, refresh the snapshot |
| addr | input | 8 | Register offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A corrupted snapshot or pending bit shows up within two edges of an input change. It appears as a source bit that reads wrong, or as an `irq_n` level that does not match (pending AND NOT mask) worked out from the stimulus. A mask bit that is stuck or lost shows up at the next read of 45h, and on `irq_n` as soon as a change arrives on that input. Masked-pending inputs are unmasked afterwards to prove that they were kept. Inputs are returned to their old value to prove that pending bits clear without a port read.

// File: rtl/chg_irq.sv
module chg_irq #(
  parameter int W = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] MASK_OFS = 8'h45,
  parameter logic [AW-1:0] SRC_OFS = 8'h46
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pins,
  input  logic          port_rd,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          irq_n
);

  logic [W-1:0] meta_q, sync_q, snap_q, mask_q;
  logic [W-1:0] pend, src;
  logic         mask_wr;

  assign mask_wr = wr_en && (addr == MASK_OFS);
  assign pend    = sync_q ^ snap_q;
  assign src     = pend & ~mask_q;
  assign irq_n   = ~|src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pins;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (port_rd) snap_q <= sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (addr == MASK_OFS)     rd_data <= mask_q;
      else if (addr == SRC_OFS) rd_data <= src;
      else                      rd_data <= '0;
    end
  end

  a_r1_mask_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '1 && irq_n));

  a_r5_unmask_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !port_rd && |((meta_q ^ snap_q) & ~wr_data)) |=> !irq_n);

  a_r6_mask_all_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && wr_data == '1) |=> irq_n);

  a_r8_port_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && meta_q == sync_q) |=> (irq_n && pend == '0));

  a_r7_src_hides_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SRC_OFS) |=> ((rd_data & $past(mask_q)) == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != SRC_OFS && addr != MASK_OFS) |=> rd_data == '0);

  a_r10_src_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != MASK_OFS) |=> $stable(mask_q));

endmodule

// File: tb/chg_irq_test.sv
module chg_irq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, port_rd = 0, wr_en = 0, rd_en = 0;
  logic [7:0] pins = 0, addr = 0, wr_data = 0;
  logic [7:0] rd_data;
  logic irq_n;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] snap = 0;
  logic [7:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_irq uut (.clk(clk), .rst_n(rst_n), .pins(pins), .port_rd(port_rd),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq_n(irq_n));

  // each entry: {pins, mask}
  localparam logic [15:0] VEC [8] = '{
    16'h01_00, 16'h03_FE, 16'h80_7F, 16'hF0_0F,
    16'h0F_F0, 16'h55_AA, 16'hAA_00, 16'h00_FF
  };

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] v);
    addr = a; wr_data = v; wr_en = 1; cyc(); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    addr = a; rd_en = 1; cyc(); rd_en = 0; v = rd_data;
  endtask

  task automatic drive(logic [7:0] v);
    pins = v; cyc(); cyc();
  endtask

  task automatic pread();
    port_rd = 1; cyc(); port_rd = 0; snap = pins;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq_n in reset", irq_n, 1);
    check("R1 rd_data in reset", rd_data, 0);
    rst_n = 1; cyc();
    rd(8'h45, d); check("R1 mask reset", d, 8'hFF);
    rd(8'h46, d); check("R1 source reset", d, 8'h00);
    check("R1 irq_n idle", irq_n, 1);

    for (int i = 0; i < 8; i++) begin
      wr(8'h45, VEC[i][7:0]);
      drive(VEC[i][15:8]);
      exp = (VEC[i][15:8] ^ snap) & ~VEC[i][7:0];
      check("R3 irq_n vector", irq_n, (exp == 0));
      rd(8'h46, d); check("R7 source vector", d, exp);
      pread(); cyc();
      check("R8 irq_n after port read", irq_n, 1);
    end

    // R2: latency of two edges
    wr(8'h45, 8'h00);
    pins = 8'h04; cyc();
    check("R2 not after first edge", irq_n, 1);
    cyc();
    check("R2 after second edge", irq_n, 0);
    pread(); cyc();
    check("R8 cleared", irq_n, 1);

    // R4/R5: masked change stays pending, unmask raises it
    wr(8'h45, 8'hFF);
    drive(8'h14);
    check("R4 masked irq_n", irq_n, 1);
    rd(8'h46, d); check("R4 masked source", d, 8'h00);
    wr(8'h45, 8'hEF);
    check("R5 unmask raises", irq_n, 0);
    rd(8'h46, d); check("R5 source after unmask", d, 8'h10);

    // R6: withdraw one of two sources
    wr(8'h45, 8'h00);
    drive(8'h15);
    rd(8'h46, d); check("R6 two sources", d, 8'h11);
    wr(8'h45, 8'h10);
    check("R6 other source remains", irq_n, 0);
    wr(8'h45, 8'h11);
    check("R6 all masked releases", irq_n, 1);
    wr(8'h45, 8'h00);

    // R9: returning to reference clears pending
    drive(8'h04);
    check("R9 back to snapshot", irq_n, 1);
    rd(8'h46, d); check("R9 source cleared", d, 8'h00);

    // R10: write to source ignored, unmapped reads zero
    drive(8'h06);
    wr(8'h46, 8'hFF);
    rd(8'h46, d); check("R10 source after write", d, 8'h02);
    rd(8'h45, d); check("R10 mask after source write", d, 8'h00);
    wr(8'h47, 8'hFF);
    rd(8'h45, d); check("R10 mask after stray write", d, 8'h00);
    rd(8'h44, d); check("R10 unmapped read", d, 8'h00);
    rd(8'h45, d); check("R7 read data holds", rd_data, 8'h00);
    wr(8'h45, 8'hA5);
    rd(8'h45, d); check("R10 mask readback", d, 8'hA5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule